// File: doc/BRIEF.md
# Two-Slot SD Card Clock Generator

This block derives the card clocks for a two-slot SD/MMC host from one fast reference clock. A first stage divides the reference by an integer from 2 to 16 with a programmable high time. It also offers two copies of its output, each with its own phase offset, for data launch and data capture. Each slot has a second-stage divider that divides the first-stage clock by an even factor or passes it through unchanged. A per-slot source selector picks which divider drives that slot. A per-slot enable and a per-slot low-power gate then decide whether the clock reaches the card.

Software-facing settings arrive on shadow inputs and stay inert until an update command completes. The writer pulses `cmdStart`, and the block raises `cmdBusy`. The block then waits for a cycle in which the first-stage clock and every card clock are low, loads all settings on that edge, restarts its counters, and drops `cmdBusy`. A new command issued while `cmdBusy` is high is refused. The block flags the refusal on `lockErr`, and the command must be issued again. No card command is ever produced by an update.

Top module: `sdcard_clkgen`

## Requirements
- R1: With first-stage settings P (1..15) and H (0..P-1), the first-stage clock has a period of P+1 reference cycles and is high for the first H+1 of them. The cycle in which the new settings load is the first high cycle.
- R2: A slot divider with setting M in 1..255 divides the first-stage clock by 2*M. Its output is low for the first M first-stage periods after an update and then toggles every M periods.
- R3: A divider setting of M = 0 passes the first-stage clock through unchanged.
- R4: The source field of slot i selects divider number `cfgSlotSrc[i]` as the source of card clock i. The value 0 selects the divider of slot 0 and the value 1 selects the divider of slot 1.
- R5: When a slot's active enable bit is 0, its card clock is held low.
- R6: When a slot's active low-power bit is 1 and its `slotIdle` input is 1, its card clock stops in its low phase and stays low. When `slotIdle` returns to 0, the clock resumes. When the low-power bit is 0, `slotIdle` has no effect.
- R7: Phase code c (0..7) shifts a phased output by floor(c*(P+1)/8) reference cycles. The output is high when ((count - offset) mod (P+1)) <= H, where count is the position within the first-stage period. Code 4 with an even period gives a half-period shift.
- R8: Changing the shadow inputs without an update command has no effect on any output clock.
- R9: `cmdBusy` rises in the cycle after `cmdStart` is sampled with `cmdBusy` low. It stays high until the settings load. The settings load only on an edge that follows a cycle in which all card clocks are low, and `cmdBusy` falls on that same edge.
- R10: If `cmdStart` is sampled while `cmdBusy` is high, `lockErr` is high for exactly the next cycle and that command is dropped.
- R11: After reset, `cmdBusy`, `lockErr` and all card clocks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | One-cycle update command request |
| cfgDivP | input | P_W | Shadow first-stage divide setting P |
| cfgHighH | input | P_W | Shadow first-stage high-time setting H |
| cfgPhaseOut | input | PH_W | Shadow phase code for the launch clock |
| cfgPhaseIn | input | PH_W | Shadow phase code for the capture clock |
| cfgSlotDiv | input | NUM_SLOTS*M_W | Shadow per-slot second-stage setting M, slot i in bits [i*M_W +: M_W] |
| cfgSlotSrc | input | NUM_SLOTS*SRC_W | Shadow per-slot divider select |
| cfgSlotEn | input | NUM_SLOTS | Shadow per-slot clock enable |
| cfgSlotLowPwr | input | NUM_SLOTS | Shadow per-slot low-power gate enable |
| slotIdle | input | NUM_SLOTS | Per-slot idle indication for low-power gating |
| cmdBusy | output | 1 | Update command pending |
| lockErr | output | 1 | One-cycle pulse for a refused command |
| cardClk | output | NUM_SLOTS | Per-slot card clock |
| doutClk | output | 1 | Phased first-stage clock for data launch |
| dinClk | output | 1 | Phased first-stage clock for data capture |

## Verification
The hardest case to reach is a refused command. A second request can only land while the first one is still waiting for a low point on every card clock, and with a short period that wait lasts only a few cycles. The stimulus therefore holds `cmdStart` high for two consecutive cycles, so the second sample always meets a raised `cmdBusy`. It then changes the shadows and confirms that the refused request never loads them. The divider and duty settings are swept over every legal P and H pair, and each sweep is aligned to the cycle in which `cmdBusy` falls.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Strobes from the update controller to the clock datapath
  typedef struct packed {
    logic apply;   // load shadow settings and restart the dividers
  } clkCtrlStrobe_t;

endpackage

// File: rtl/sdcard_clkgen_ctrl.sv
module sdcard_clkgen_ctrl
  import sdclk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmdStart,
  input  logic           safePoint,
  output clkCtrlStrobe_t strobe,
  output logic           cmdBusy,
  output logic           lockErr
);

  logic busyQ;
  logic lockQ;

  always_comb begin
    strobe       = '0;
    strobe.apply = busyQ & safePoint;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      lockQ <= 1'b0;
    end else begin
      // a request seen while pending is refused and dropped
      lockQ <= cmdStart & busyQ;
      if (busyQ) busyQ <= ~strobe.apply;
      else       busyQ <= cmdStart;
    end
  end

  assign cmdBusy = busyQ;
  assign lockErr = lockQ;

endmodule

// File: rtl/sdcard_clkgen_dp.sv
module sdcard_clkgen_dp
  import sdclk_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int P_W       = 4,
  parameter int M_W       = 8,
  parameter int PH_W      = 3,
  parameter int SRC_W     = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  clkCtrlStrobe_t             strobe,
  input  logic [P_W-1:0]             cfgDivP,
  input  logic [P_W-1:0]             cfgHighH,
  input  logic [PH_W-1:0]            cfgPhaseOut,
  input  logic [PH_W-1:0]            cfgPhaseIn,
  input  logic [NUM_SLOTS*M_W-1:0]   cfgSlotDiv,
  input  logic [NUM_SLOTS*SRC_W-1:0] cfgSlotSrc,
  input  logic [NUM_SLOTS-1:0]       cfgSlotEn,
  input  logic [NUM_SLOTS-1:0]       cfgSlotLowPwr,
  input  logic [NUM_SLOTS-1:0]       slotIdle,
  output logic                       safePoint,
  output logic [NUM_SLOTS-1:0]       cardClk,
  output logic                       doutClk,
  output logic                       dinClk
);

  localparam int IW = P_W + 2;   // wide enough for count + period
  localparam int PW = IW + PH_W; // phase product width

  // active (loaded) settings
  logic [P_W-1:0]   pAct, hAct, cnt;
  logic [PH_W-1:0]  phOutAct, phInAct;
  logic [M_W-1:0]   mAct   [NUM_SLOTS];
  logic [SRC_W-1:0] srcAct [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] enAct, lpAct;

  logic tick, s1Clk;
  logic [NUM_SLOTS-1:0] divClk, srcClk, gateQ;

  function automatic logic phaseLevel(input logic [PH_W-1:0] code,
                                      input logic [P_W-1:0]  cntV,
                                      input logic [P_W-1:0]  pV,
                                      input logic [P_W-1:0]  hV);
    logic [IW-1:0] period;
    logic [IW-1:0] off;
    logic [IW-1:0] idx;
    logic [PW-1:0] prod;
    period = IW'(pV) + IW'(1);
    prod   = PW'(code) * PW'(period);
    off    = IW'(prod >> PH_W);
    idx    = IW'(cntV) + period - off;
    if (idx >= period) idx = idx - period;
    return idx <= IW'(hV);
  endfunction

  // first stage: period pAct+1, high for hAct+1 cycles
  assign tick  = (cnt == pAct);
  assign s1Clk = (cnt <= hAct);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pAct     <= P_W'(1);
      hAct     <= '0;
      phOutAct <= '0;
      phInAct  <= '0;
      enAct    <= '0;
      lpAct    <= '0;
      cnt      <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        mAct[i]   <= '0;
        srcAct[i] <= SRC_W'(i);
      end
    end else if (strobe.apply) begin
      pAct     <= cfgDivP;
      hAct     <= cfgHighH;
      phOutAct <= cfgPhaseOut;
      phInAct  <= cfgPhaseIn;
      enAct    <= cfgSlotEn;
      lpAct    <= cfgSlotLowPwr;
      cnt      <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        mAct[i]   <= cfgSlotDiv[i*M_W +: M_W];
        srcAct[i] <= cfgSlotSrc[i*SRC_W +: SRC_W];
      end
    end else begin
      cnt <= tick ? '0 : cnt + P_W'(1);
    end
  end

  // second stage and gating, one per slot
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [M_W-1:0] c2;
    logic           dv;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c2 <= '0;
        dv <= 1'b0;
      end else if (strobe.apply) begin
        c2 <= '0;
        dv <= 1'b0;
      end else if (tick && (mAct[g] != '0)) begin
        if (c2 == mAct[g] - M_W'(1)) begin
          c2 <= '0;
          dv <= ~dv;
        end else begin
          c2 <= c2 + M_W'(1);
        end
      end
    end

    assign divClk[g] = (mAct[g] == '0) ? s1Clk : dv;
    assign srcClk[g] = divClk[srcAct[g]];

    // gate changes only while the selected source is low
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gateQ[g] <= 1'b0;
      end else if (strobe.apply) begin
        gateQ[g] <= cfgSlotEn[g] & ~(cfgSlotLowPwr[g] & slotIdle[g]);
      end else if (!srcClk[g]) begin
        gateQ[g] <= enAct[g] & ~(lpAct[g] & slotIdle[g]);
      end
    end

    assign cardClk[g] = gateQ[g] & srcClk[g];
  end

  assign safePoint = tick & ~s1Clk & (cardClk == '0);

  always_comb begin
    doutClk = phaseLevel(phOutAct, cnt, pAct, hAct);
    dinClk  = phaseLevel(phInAct,  cnt, pAct, hAct);
  end

endmodule

// File: rtl/sdcard_clkgen.sv
module sdcard_clkgen
  import sdclk_pkg::*;
#(
  parameter  int NUM_SLOTS = 2,
  parameter  int P_W       = 4,
  parameter  int M_W       = 8,
  parameter  int PH_W      = 3,
  localparam int SRC_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmdStart,
  input  logic [P_W-1:0]             cfgDivP,
  input  logic [P_W-1:0]             cfgHighH,
  input  logic [PH_W-1:0]            cfgPhaseOut,
  input  logic [PH_W-1:0]            cfgPhaseIn,
  input  logic [NUM_SLOTS*M_W-1:0]   cfgSlotDiv,
  input  logic [NUM_SLOTS*SRC_W-1:0] cfgSlotSrc,
  input  logic [NUM_SLOTS-1:0]       cfgSlotEn,
  input  logic [NUM_SLOTS-1:0]       cfgSlotLowPwr,
  input  logic [NUM_SLOTS-1:0]       slotIdle,
  output logic                       cmdBusy,
  output logic                       lockErr,
  output logic [NUM_SLOTS-1:0]       cardClk,
  output logic                       doutClk,
  output logic                       dinClk
);

  clkCtrlStrobe_t strobe;
  logic           safePoint;

  sdcard_clkgen_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdStart  (cmdStart),
    .safePoint (safePoint),
    .strobe    (strobe),
    .cmdBusy   (cmdBusy),
    .lockErr   (lockErr)
  );

  sdcard_clkgen_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .P_W       (P_W),
    .M_W       (M_W),
    .PH_W      (PH_W),
    .SRC_W     (SRC_W)
  ) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .cfgDivP       (cfgDivP),
    .cfgHighH      (cfgHighH),
    .cfgPhaseOut   (cfgPhaseOut),
    .cfgPhaseIn    (cfgPhaseIn),
    .cfgSlotDiv    (cfgSlotDiv),
    .cfgSlotSrc    (cfgSlotSrc),
    .cfgSlotEn     (cfgSlotEn),
    .cfgSlotLowPwr (cfgSlotLowPwr),
    .slotIdle      (slotIdle),
    .safePoint     (safePoint),
    .cardClk       (cardClk),
    .doutClk       (doutClk),
    .dinClk        (dinClk)
  );

endmodule

// File: rtl/sdcard_clkgen_chk.sv
module sdcard_clkgen_chk #(
  parameter int NUM_SLOTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmdStart,
  input logic                 cmdBusy,
  input logic                 lockErr,
  input logic [NUM_SLOTS-1:0] cardClk
);

  a_r10_lock_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && cmdBusy) |=> lockErr);

  a_r10_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lockErr |-> $past(cmdStart && cmdBusy));

  a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && !cmdBusy) |=> cmdBusy);

  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmdBusy && !cmdStart) |=> !cmdBusy);

  a_r9_load_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmdBusy) |-> ($past(cardClk) == '0));

endmodule

bind sdcard_clkgen sdcard_clkgen_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmdStart (cmdStart),
  .cmdBusy  (cmdBusy),
  .lockErr  (lockErr),
  .cardClk  (cardClk)
);

// File: tb/sdcard_clkgen_tb_top.sv
module sdcard_clkgen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdStart = 1'b0;
  logic [3:0] cfgDivP = 4'd1;
  logic [3:0] cfgHighH = 4'd0;
  logic [2:0] cfgPhaseOut = '0;
  logic [2:0] cfgPhaseIn = '0;
  logic [NS*MW-1:0] cfgSlotDiv = '0;
  logic [NS-1:0] cfgSlotSrc = 2'b10;
  logic [NS-1:0] cfgSlotEn = '0;
  logic [NS-1:0] cfgSlotLowPwr = '0;
  logic [NS-1:0] slotIdle = '0;
  logic cmdBusy, lockErr, doutClk, dinClk;
  logic [NS-1:0] cardClk;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcard_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart),
    .cfgDivP(cfgDivP), .cfgHighH(cfgHighH),
    .cfgPhaseOut(cfgPhaseOut), .cfgPhaseIn(cfgPhaseIn),
    .cfgSlotDiv(cfgSlotDiv), .cfgSlotSrc(cfgSlotSrc),
    .cfgSlotEn(cfgSlotEn), .cfgSlotLowPwr(cfgSlotLowPwr),
    .slotIdle(slotIdle), .cmdBusy(cmdBusy), .lockErr(lockErr),
    .cardClk(cardClk), .doutClk(doutClk), .dinClk(dinClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expS1(input int k, input int p, input int h);
    return (k % (p + 1)) <= h;
  endfunction

  function automatic bit expDiv(input int k, input int p, input int m);
    return (((k / (p + 1)) / m) % 2) == 1;
  endfunction

  function automatic bit expPh(input int k, input int p, input int h, input int code);
    int off = (code * (p + 1)) / 8;
    int idx = ((k % (p + 1)) + (p + 1) - off) % (p + 1);
    return idx <= h;
  endfunction

  // Issue an update; returns at the first negedge with cmdBusy low (k = 0)
  task automatic doUpdate();
    int w = 0;
    logic [NS-1:0] prevCard;
    @(negedge clk) cmdStart = 1'b1;
    @(negedge clk) cmdStart = 1'b0;
    check(cmdBusy == 1'b1, "R9 busy after start", cmdBusy, 1);
    prevCard = cardClk;
    while (cmdBusy && w < 20000) begin
      prevCard = cardClk;
      @(negedge clk);
      w++;
    end
    check(prevCard == '0, "R9 load at low point", prevCard, 0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    int bad2;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cmdBusy == 1'b0, "R11 busy", cmdBusy, 0);
    check(lockErr == 1'b0, "R11 lockErr", lockErr, 0);
    check(cardClk == '0, "R11 cardClk", cardClk, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cardClk == '0 && !cmdBusy, "R11 after release", cardClk, 0);

    // R1 / R3 / R5: full P,H sweep, slot 0 bypass, slot 1 disabled
    bad2 = 0;
    for (int p = 1; p <= 15; p++) begin
      for (int h = 0; h < p; h++) begin
        cfgDivP = 4'(p); cfgHighH = 4'(h);
        cfgSlotDiv = '0; cfgSlotSrc = 2'b10;
        cfgSlotEn = 2'b01; cfgSlotLowPwr = '0;
        doUpdate();
        bad = 0;
        for (int k = 0; k < 2 * (p + 1); k++) begin
          if (cardClk[0] != expS1(k, p, h)) bad++;
          if (cardClk[1] != 1'b0) bad2++;
          @(negedge clk);
        end
        check(bad == 0, $sformatf("R1 R3 p=%0d h=%0d mismatches", p, h), bad, 0);
      end
    end
    check(bad2 == 0, "R5 disabled slot high cycles", bad2, 0);

    // R2 / R4: even division, crossed source selection
    begin
      int pl[3] = '{1, 2, 4};
      int m0l[4] = '{1, 2, 3, 255};
      int m1l[4] = '{2, 1, 5, 3};
      foreach (pl[a]) begin
        foreach (m0l[b]) begin
          int p = pl[a];
          int m0 = m0l[b];
          int m1 = m1l[b];
          int mx = (m0 > m1) ? m0 : m1;
          cfgDivP = 4'(p); cfgHighH = 4'(0);
          cfgSlotDiv = {8'(m1), 8'(m0)};
          cfgSlotSrc = 2'b01;   // slot0 <- divider 1, slot1 <- divider 0
          cfgSlotEn = 2'b11; cfgSlotLowPwr = '0;
          doUpdate();
          bad = 0; bad2 = 0;
          for (int k = 0; k < 2 * (p + 1) * mx + (p + 1); k++) begin
            if (cardClk[0] != expDiv(k, p, m1)) bad++;
            if (cardClk[1] != expDiv(k, p, m0)) bad2++;
            @(negedge clk);
          end
          check(bad == 0, $sformatf("R2 R4 slot0 p=%0d m=%0d", p, m1), bad, 0);
          check(bad2 == 0, $sformatf("R2 R4 slot1 p=%0d m=%0d", p, m0), bad2, 0);
        end
      end
    end

    // R7: phase codes
    begin
      int pl[3] = '{7, 5, 3};
      foreach (pl[a]) begin
        int p = pl[a];
        int h = (p + 1) / 2 - 1;
        for (int c = 0; c < 8; c++) begin
          cfgDivP = 4'(p); cfgHighH = 4'(h);
          cfgPhaseOut = 3'(c); cfgPhaseIn = 3'(7 - c);
          cfgSlotDiv = '0; cfgSlotEn = 2'b01; cfgSlotSrc = 2'b10;
          doUpdate();
          bad = 0;
          for (int k = 0; k < 2 * (p + 1); k++) begin
            if (doutClk != expPh(k, p, h, c)) bad++;
            if (dinClk != expPh(k, p, h, 7 - c)) bad++;
            @(negedge clk);
          end
          check(bad == 0, $sformatf("R7 p=%0d code=%0d", p, c), bad, 0);
        end
      end
    end

    // R6: low-power gating
    cfgDivP = 4'd3; cfgHighH = 4'd1; cfgSlotDiv = '0; cfgSlotSrc = 2'b10;
    cfgSlotEn = 2'b01; cfgSlotLowPwr = 2'b01; slotIdle = 2'b01;
    doUpdate();
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      if (cardClk[0]) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6 idle low-power held low", bad, 0);
    slotIdle = 2'b00;
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      if (cardClk[0]) bad++;
      @(negedge clk);
    end
    check(bad > 0, "R6 resumes when not idle", bad, 1);
    slotIdle = 2'b01;
    repeat (8) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      if (cardClk[0]) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6 stops again when idle", bad, 0);
    cfgSlotLowPwr = 2'b00;
    doUpdate();
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      if (cardClk[0] != expS1(k, 3, 1)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6 idle ignored without low-power", bad, 0);
    slotIdle = 2'b00;

    // R8: shadow changes without an update do nothing
    cfgDivP = 4'd3; cfgHighH = 4'd1; cfgSlotEn = 2'b01;
    doUpdate();
    cfgDivP = 4'd9; cfgHighH = 4'd4; cfgSlotEn = 2'b00; cfgPhaseOut = 3'd4;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (cardClk[0] != expS1(k, 3, 1)) bad++;
      if (cmdBusy) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 shadow inert", bad, 0);

    // R10: refused command while pending
    cfgDivP = 4'd3; cfgHighH = 4'd1; cfgSlotEn = 2'b01; cfgPhaseOut = '0;
    @(negedge clk) cmdStart = 1'b1;
    @(negedge clk);               // second sample meets cmdBusy high
    @(negedge clk) cmdStart = 1'b0;
    check(lockErr == 1'b1, "R10 lockErr pulse", lockErr, 1);
    @(negedge clk);
    check(lockErr == 1'b0, "R10 lockErr one cycle", lockErr, 0);
    begin
      int w = 0;
      while (cmdBusy && w < 1000) begin @(negedge clk); w++; end
    end
    // settings of the accepted command are now active; the dropped one must not reload
    cfgDivP = 4'd9; cfgHighH = 4'd4;
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      if (cmdBusy) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10 dropped command never loads", bad, 0);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (cardClk[0]) bad++;
      @(negedge clk);
    end
    check(bad == 20, "R10 old duty kept (high cycles in 40)", bad, 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule